// File: doc/BRIEF.md
# Keyed Bus Encryptor

This block sits on the byte-wide external memory bus of an 8-bit processor core, between the core and an external SRAM. The core issues a logical address, a read strobe or a write strobe, and write data. The block drives a scrambled physical address, the encrypted write byte and the bus direction controls to the memory. It also decrypts the byte that the memory returns before handing it back to the core. The same logic serves code loading and normal execution, so memory always holds only scrambled, encrypted contents.

Both transforms take their secrets from one 64-bit key input. The address transform is a keyed bit permutation with masks, so it is a bijection and it spreads neighbouring logical addresses apart. The data transform uses a different algorithm. It XORs the byte with a pad derived from the key and the physical address, then applies a key-chosen bit rotation and an optional bit reversal. Equal bytes therefore store as different values at different locations. Every path is combinational, so the memory bus needs no wait states.

Top module: `cryptbus_top`

## Requirements
- R1: In the same cycle, `memAddr` equals `rotl16(cpuAddr ^ key[15:0], r) ^ key[35:20]`, where `r = (key[19:16] mod 15) + 1` and rotl16 rotates left toward the most significant bit.
- R2: For a fixed key, no two logical addresses produce the same `memAddr`.
- R3: For a fixed key and a logical address `a` whose bits [14:0] are not all ones, the physical addresses of `a` and `a+1` differ numerically by more than one.
- R4: During a write, `memWrData` equals `perm(cpuWrData ^ pad)`. Here `pad = pa[7:0] ^ K[pa[10:8]] ^ {pa[11:8], pa[15:12]}`, with `pa = memAddr` and key byte `K[i] = key[8i+7:8i]`. `perm` rotates the byte left by `key[63:61]` and then reverses its bit order when `key[60]` is 1.
- R5: For a fixed key, writing the same byte to physical addresses that share bits [15:8] but differ in bits [7:0] stores a different value at each address.
- R6: During a read, `cpuRdData` equals the exact inverse of R4 applied to `memRdData` with `pa = memAddr`, in the same cycle. A byte written and then read back at the same logical address therefore returns unchanged.
- R7: When `cpuWr` is 1, `memWr` and `memDataOe` are 1 and `memRd` is 0.
- R8: When `cpuRd` is 1 and `cpuWr` is 0, `memRd` is 1, `memWr` and `memDataOe` are 0, and `cpuRdData` carries the decrypted byte. In every other case `cpuRdData` is 0.
- R9: When `cpuRd` and `cpuWr` are both 1, the write is performed and the read is ignored: `memRd` is 0 and `cpuRdData` is 0.
- R10: With neither strobe asserted, `memRd`, `memWr` and `memDataOe` are all 0 while `memAddr` still follows R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the embedded bus checks |
| rstN | input | 1 | Active-low reset; holds the checks off |
| key | input | 64 | Cipher key shared by the address and data transforms |
| cpuAddr | input | 16 | Logical address from the core |
| cpuRd | input | 1 | Core read strobe |
| cpuWr | input | 1 | Core write strobe |
| cpuWrData | input | 8 | Plain write byte from the core |
| cpuRdData | output | 8 | Decrypted read byte to the core |
| memAddr | output | 16 | Scrambled physical address to the SRAM |
| memRd | output | 1 | Memory read enable |
| memWr | output | 1 | Memory write enable |
| memDataOe | output | 1 | Enable for driving the memory data bus |
| memWrData | output | 8 | Encrypted write byte to the SRAM |
| memRdData | input | 8 | Encrypted byte returned by the SRAM |

## Verification
A fault in the rotation amount or a mask shows up on `memAddr` at once, in the same cycle as the logical address. A fault that breaks the permutation appears as a repeated physical address during a full address sweep. A wrong pad or a wrong byte permutation corrupts `memWrData` on the first write. It also surfaces when that location is read back, because the returned byte then differs from what was written. A strobe decode fault appears immediately on the direction pins or as a non-zero read byte outside a read cycle.

// File: rtl/cryptbus_pkg.sv
package cryptbus_pkg;

  // Strobes sent from the bus control to the datapath
  typedef struct packed {
    logic wrCycle;    // memory write in progress
    logic rdCycle;    // memory read in progress
    logic driveBus;   // data bus driven toward memory
    logic returnRead; // decrypted byte handed back to the core
  } busStrobes_t;

endpackage

// File: rtl/cryptbus_ctrl.sv
module cryptbus_ctrl
  import cryptbus_pkg::*;
(
  input  logic        cpuRd,
  input  logic        cpuWr,
  output busStrobes_t strobes
);

  logic readOnly;

  // a write outranks a simultaneous read
  assign readOnly = cpuRd & ~cpuWr;

  always_comb begin
    strobes            = '0;
    strobes.wrCycle    = cpuWr;
    strobes.driveBus   = cpuWr;
    strobes.rdCycle    = readOnly;
    strobes.returnRead = readOnly;
  end

endmodule

// File: rtl/cryptbus_addr_scrambler.sv
module cryptbus_addr_scrambler #(
  parameter int ADDR_W = 16,
  parameter int KEY_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [KEY_W-1:0]  key,
  input  logic [ADDR_W-1:0] logAddr,
  output logic [ADDR_W-1:0] physAddr
);

  localparam int ROT_W    = $clog2(ADDR_W);
  localparam int ROT_LO   = ADDR_W;
  localparam int MASKB_LO = ADDR_W + ROT_W;

  logic [ADDR_W-1:0]   maskIn;
  logic [ADDR_W-1:0]   maskOut;
  logic [ROT_W-1:0]    rotField;
  logic [ROT_W:0]      rotAmt;
  logic [ADDR_W-1:0]   mixed;
  logic [2*ADDR_W-1:0] dblRot;

  assign maskIn   = key[ADDR_W-1:0];
  assign rotField = key[ROT_LO +: ROT_W];
  assign maskOut  = key[MASKB_LO +: ADDR_W];

  // rotation forced into 1 .. ADDR_W-1 so it never collapses to identity
  assign rotAmt = ({1'b0, rotField} % (ROT_W+1)'(ADDR_W - 1)) + (ROT_W+1)'(1);

  assign mixed    = logAddr ^ maskIn;
  assign dblRot   = {mixed, mixed} << rotAmt;
  assign physAddr = dblRot[2*ADDR_W-1:ADDR_W] ^ maskOut;

  // checker: walk the transform backwards
  logic [ADDR_W-1:0]   backMixed;
  logic [2*ADDR_W-1:0] backDbl;
  logic [ADDR_W-1:0]   backAddr;

  assign backMixed = physAddr ^ maskOut;
  assign backDbl   = {backMixed, backMixed} >> rotAmt;
  assign backAddr  = backDbl[ADDR_W-1:0] ^ maskIn;

  AST_ADDR_INVERTS: assert property (@(posedge clk) disable iff (!rstN)
    backAddr == logAddr); // R2

  AST_NEIGHBOUR_APART: assert property (@(posedge clk) disable iff (!rstN)
    (logAddr == ADDR_W'($past(logAddr) + 1'b1) && $stable(key) &&
     $past(logAddr[ADDR_W-2:0]) != {(ADDR_W-1){1'b1}})
    |-> (ADDR_W'(physAddr - $past(physAddr)) != ADDR_W'(1) &&
         ADDR_W'($past(physAddr) - physAddr) != ADDR_W'(1))); // R3

endmodule

// File: rtl/cryptbus_data_cipher.sv
module cryptbus_data_cipher #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int KEY_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [KEY_W-1:0]  key,
  input  logic [ADDR_W-1:0] physAddr,
  input  logic [DATA_W-1:0] plainIn,
  output logic [DATA_W-1:0] cipherOut,
  input  logic [DATA_W-1:0] cipherIn,
  output logic [DATA_W-1:0] plainOut
);

  localparam int KEY_BYTES = KEY_W / DATA_W;
  localparam int IDX_W     = $clog2(KEY_BYTES);
  localparam int DROT_W    = $clog2(DATA_W);
  localparam int HALF      = DATA_W / 2;

  logic [DATA_W-1:0] keyBytes [KEY_BYTES];
  logic [DATA_W-1:0] pageBits;
  logic [DATA_W-1:0] pageSwap;
  logic [IDX_W-1:0]  byteSel;
  logic [DATA_W-1:0] pad;
  logic [DROT_W-1:0] dRot;
  logic              revFlag;

  for (genvar g = 0; g < KEY_BYTES; g++) begin : gKeyBytes
    assign keyBytes[g] = key[g*DATA_W +: DATA_W];
  end

  assign pageBits = physAddr[ADDR_W-1 -: DATA_W];
  assign pageSwap = {pageBits[HALF-1:0], pageBits[DATA_W-1:HALF]};
  assign byteSel  = pageBits[IDX_W-1:0];
  assign pad      = physAddr[DATA_W-1:0] ^ keyBytes[byteSel] ^ pageSwap;
  assign dRot     = key[KEY_W-1 -: DROT_W];
  assign revFlag  = key[KEY_W-1-DROT_W];

  // encrypt: whiten, rotate, optionally mirror
  logic [DATA_W-1:0]   encMix;
  logic [2*DATA_W-1:0] encDbl;
  logic [DATA_W-1:0]   encRot;
  logic [DATA_W-1:0]   encRev;

  assign encMix = plainIn ^ pad;
  assign encDbl = {encMix, encMix} << dRot;
  assign encRot = encDbl[2*DATA_W-1:DATA_W];

  // decrypt: un-mirror, rotate back, remove whitening
  logic [DATA_W-1:0]   decRev;
  logic [DATA_W-1:0]   decIn;
  logic [2*DATA_W-1:0] decDbl;

  for (genvar b = 0; b < DATA_W; b++) begin : gMirror
    assign encRev[b] = encRot[DATA_W-1-b];
    assign decRev[b] = cipherIn[DATA_W-1-b];
  end

  assign cipherOut = revFlag ? encRev : encRot;
  assign decIn     = revFlag ? decRev : cipherIn;
  assign decDbl    = {decIn, decIn} >> dRot;
  assign plainOut  = decDbl[DATA_W-1:0] ^ pad;

  AST_CIPHER_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rstN)
    (cipherIn == cipherOut) |-> (plainOut == plainIn)); // R6

endmodule

// File: rtl/cryptbus_datapath.sv
module cryptbus_datapath
  import cryptbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int KEY_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strobes,
  input  logic [KEY_W-1:0]  key,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData
);

  logic [ADDR_W-1:0] physAddr;
  logic [DATA_W-1:0] decoded;

  cryptbus_addr_scrambler #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) uScrambler (
    .clk      (clk),
    .rstN     (rstN),
    .key      (key),
    .logAddr  (cpuAddr),
    .physAddr (physAddr)
  );

  cryptbus_data_cipher #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY_W(KEY_W)) uCipher (
    .clk       (clk),
    .rstN      (rstN),
    .key       (key),
    .physAddr  (physAddr),
    .plainIn   (cpuWrData),
    .cipherOut (memWrData),
    .cipherIn  (memRdData),
    .plainOut  (decoded)
  );

  assign memAddr   = physAddr;
  assign cpuRdData = strobes.returnRead ? decoded : '0;

endmodule

// File: rtl/cryptbus_top.sv
module cryptbus_top
  import cryptbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int KEY_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [KEY_W-1:0]  key,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic              memDataOe,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData
);

  busStrobes_t strobes;

  cryptbus_ctrl uCtrl (
    .cpuRd   (cpuRd),
    .cpuWr   (cpuWr),
    .strobes (strobes)
  );

  cryptbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .key       (key),
    .cpuAddr   (cpuAddr),
    .cpuWrData (cpuWrData),
    .cpuRdData (cpuRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .memRdData (memRdData)
  );

  assign memRd     = strobes.rdCycle;
  assign memWr     = strobes.wrCycle;
  assign memDataOe = strobes.driveBus;

  AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> cpuWr); // R7

  AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuRd && !cpuWr) |-> (cpuRdData == '0 && !memRd)); // R8

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && cpuWr) |-> (memWr && !memRd)); // R9

endmodule

// File: tb/cryptbus_top_test.sv
module cryptbus_top_test;

  localparam logic [63:0] KEY_A = 64'h9E37_79B9_7F4A_7C15;
  localparam logic [63:0] KEY_B = 64'h0123_4567_89AB_CDEF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] key = KEY_A;
  logic [15:0] cpuAddr = '0;
  logic        cpuRd = 1'b0;
  logic        cpuWr = 1'b0;
  logic [7:0]  cpuWrData = '0;
  logic [7:0]  cpuRdData;
  logic [15:0] memAddr;
  logic        memRd, memWr, memDataOe;
  logic [7:0]  memWrData;
  logic [7:0]  memRdData = '0;

  int total = 0;
  int bad = 0;

  logic [7:0] sram [int];
  bit         seen [65536];

  always #10 clk = ~clk;

  cryptbus_top uut (
    .clk(clk), .rstN(rstN), .key(key), .cpuAddr(cpuAddr), .cpuRd(cpuRd),
    .cpuWr(cpuWr), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memDataOe(memDataOe),
    .memWrData(memWrData), .memRdData(memRdData)
  );

  // behavioural model of the requirements
  function automatic int rotOf(logic [63:0] k);
    return (int'(k[19:16]) % 15) + 1;
  endfunction

  function automatic logic [15:0] refScr(logic [63:0] k, logic [15:0] a);
    logic [15:0] x = a ^ k[15:0];
    logic [15:0] y;
    int r = rotOf(k);
    for (int b = 0; b < 16; b++) y[(b + r) % 16] = x[b];
    return y ^ k[35:20];
  endfunction

  function automatic logic [15:0] refUnscr(logic [63:0] k, logic [15:0] p);
    logic [15:0] x = p ^ k[35:20];
    logic [15:0] y;
    int r = rotOf(k);
    for (int b = 0; b < 16; b++) y[b] = x[(b + r) % 16];
    return y ^ k[15:0];
  endfunction

  function automatic logic [7:0] refPad(logic [63:0] k, logic [15:0] pa);
    int idx = int'(pa[10:8]);
    return pa[7:0] ^ k[idx*8 +: 8] ^ {pa[11:8], pa[15:12]};
  endfunction

  function automatic logic [7:0] refEnc(logic [63:0] k, logic [15:0] pa, logic [7:0] d);
    logic [7:0] t = d ^ refPad(k, pa);
    logic [7:0] u;
    logic [7:0] v;
    int rr = int'(k[63:61]);
    for (int b = 0; b < 8; b++) u[(b + rr) % 8] = t[b];
    for (int b = 0; b < 8; b++) v[b] = k[60] ? u[7-b] : u[b];
    return v;
  endfunction

  task automatic check(bit ok, string req, int actual, int expected);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic drive(logic [15:0] a, logic rd, logic wr, logic [7:0] wd);
    @(negedge clk);
    cpuAddr = a; cpuRd = rd; cpuWr = wr; cpuWrData = wd;
    #5;
  endtask

  task automatic busWrite(logic [15:0] a, logic [7:0] d, output logic [7:0] stored);
    logic [15:0] pa;
    drive(a, 1'b0, 1'b1, d);
    pa = refScr(key, a);
    check(memAddr == pa, "R1", memAddr, pa);
    check(memWr && memDataOe && !memRd, "R7", {memWr, memDataOe, memRd}, 3'b110);
    check(memWrData == refEnc(key, pa, d), "R4", memWrData, refEnc(key, pa, d));
    stored = memWrData;
    sram[int'(memAddr)] = memWrData;
    memRdData = memWrData; // bus echo
  endtask

  task automatic busRead(logic [15:0] a, logic [7:0] expect_d);
    @(negedge clk);
    cpuAddr = a; cpuRd = 1'b1; cpuWr = 1'b0;
    #2;
    memRdData = sram.exists(int'(memAddr)) ? sram[int'(memAddr)] : 8'h00;
    #3;
    check(memRd && !memWr && !memDataOe, "R8", {memRd, memWr, memDataOe}, 3'b100);
    check(cpuRdData == expect_d, "R6", cpuRdData, expect_d);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] prevPhys;
    logic [7:0]  st;
    logic [7:0]  pageVals [16];

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 idle bus
    drive(16'h0000, 1'b0, 1'b0, 8'h00);
    check(!memRd && !memWr && !memDataOe, "R10", {memRd, memWr, memDataOe}, 0);
    check(cpuRdData == 8'h00, "R8", cpuRdData, 0);

    // full sweep with key A: R1, R2, R3
    prevPhys = '0;
    for (int a = 0; a < 65536; a++) begin
      drive(16'(a), 1'b0, 1'b0, 8'h00);
      check(memAddr == refScr(key, 16'(a)), "R1", memAddr, refScr(key, 16'(a)));
      check(!seen[int'(memAddr)], "R2", memAddr, refUnscr(key, memAddr));
      seen[int'(memAddr)] = 1'b1;
      if (a > 0 && ((a - 1) & 16'h7FFF) != 16'h7FFF) begin
        check(16'(memAddr - prevPhys) != 16'd1 && 16'(prevPhys - memAddr) != 16'd1,
              "R3", memAddr, prevPhys);
      end
      prevPhys = memAddr;
    end

    // partial sweep with key B, idle strobes
    key = KEY_B;
    for (int a = 16'h4000; a < 16'h4400; a++) begin
      drive(16'(a), 1'b0, 1'b0, 8'h00);
      check(memAddr == refScr(key, 16'(a)), "R1", memAddr, refScr(key, 16'(a)));
      check(!memRd && !memWr && !memDataOe, "R10", {memRd, memWr, memDataOe}, 0);
    end

    // block write and readback under both keys
    for (int kk = 0; kk < 2; kk++) begin
      key = (kk == 0) ? KEY_A : KEY_B;
      sram.delete();
      for (int j = 0; j < 64; j++)
        busWrite(16'h1230 + 16'(j), (j < 32) ? 8'hA5 : 8'(j * 7 + 1), st);
      for (int j = 0; j < 64; j++)
        busRead(16'h1230 + 16'(j), (j < 32) ? 8'hA5 : 8'(j * 7 + 1));
    end

    // R5: same byte inside one physical page
    key = KEY_A;
    for (int j = 0; j < 16; j++) begin
      busWrite(refUnscr(key, 16'h5A00 + 16'(j * 13)), 8'h3C, st);
      pageVals[j] = st;
    end
    for (int i = 0; i < 16; i++)
      for (int j = i + 1; j < 16; j++)
        check(pageVals[i] != pageVals[j], "R5", pageVals[i], pageVals[j]);
    for (int j = 0; j < 16; j++)
      busRead(refUnscr(key, 16'h5A00 + 16'(j * 13)), 8'h3C);

    // R9: both strobes
    @(negedge clk);
    cpuAddr = 16'h0777; cpuRd = 1'b1; cpuWr = 1'b1; cpuWrData = 8'h5E; memRdData = 8'hFF;
    #5;
    check(memWr && memDataOe && !memRd, "R9", {memWr, memDataOe, memRd}, 3'b110);
    check(cpuRdData == 8'h00, "R9", cpuRdData, 0);
    check(memWrData == refEnc(key, refScr(key, 16'h0777), 8'h5E), "R9",
          memWrData, refEnc(key, refScr(key, 16'h0777), 8'h5E));

    drive(16'h0000, 1'b0, 1'b0, 8'h00);
    check(cpuRdData == 8'h00 && !memRd && !memWr, "R10", cpuRdData, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule